// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block sits between a set of interrupt-requesting devices and a processor core. The devices are split into 2^k priority levels, each holding a fixed number of device slots. The controller keeps the level of the handler that is running. From that level it derives a priority mask that opens only the strictly higher levels. The mask is combined with a per-device enable register and a global interrupt-enable flag. From what remains it raises one interrupt line and reports the winning level and the slot within that level.

When the core accepts the interrupt, the acknowledge travels along the winning level's chain from slot 0 upward. The first requesting slot takes it. The controller saves the previous level context on a small stack, makes the acknowledged level current and clears the global enable. Software sets the global enable again once it has saved its return state. A return strobe pops the stack and restores the previous level. It also sets the global enable again, so a lower-level handler can be resumed or a pending higher request can be taken. Device index d maps to level d / D and slot d % D, where D is the number of slots per level.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, `irq_o`, `gie_o`, `cur_valid_o`, `err_o`, `dev_ack_o`, `irq_lvl_o` and `irq_pos_o` are all zero, and every device enable is clear.
- R2: A request is eligible only when its enable bit is set and its level is open. With no handler running (`cur_valid_o` = 0), all levels are open. While a level-j handler runs, only levels numerically greater than j are open. An enable written through `en_we_i` takes effect from the next cycle.
- R3: `irq_o` is high exactly when `gie_o` is high and at least one request is eligible. `irq_lvl_o` and `irq_pos_o` show the winner whenever any request is eligible, whatever the state of `gie_o`, and are zero when none is.
- R4: The numerically highest level holding an eligible request wins, and a running handler can be preempted only by a higher level.
- R5: Within the winning level, the eligible request in the lowest slot wins. Slot order carries no priority meaning beyond chain position.
- R6: While an acknowledge is accepted (`ack_i` high, `irq_o` high, `rti_i` low), `dev_ack_o` has exactly one bit set, at index `irq_lvl_o`*D + `irq_pos_o`. Otherwise it is zero.
- R7: After an accepted acknowledge, from the next cycle, the prior context is on the stack, `cur_valid_o` is 1, `cur_lvl_o` equals the acknowledged level and `gie_o` is 0.
- R8: `gie_set_i` sets `gie_o` from the next cycle, unless an acknowledge is accepted in the same cycle, in which case the clear wins.
- R9: `rti_i` with a non-empty stack restores the most recently saved context (`cur_valid_o`, `cur_lvl_o`) and sets `gie_o` from the next cycle.
- R10: `rti_i` on an empty stack, or an accepted acknowledge with a full stack (depth 2^k), sets `err_o`. An underflow leaves the context and `gie_o` unchanged. `err_o` stays set until reset.
- R11: `ack_i` while `irq_o` is low, and `ack_i` in a cycle with `rti_i` high, change no state and drive no `dev_ack_o` bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_i | input | 2^k*D | Device request lines |
| en_we_i | input | 1 | Write strobe for the enable register |
| en_wdata_i | input | 2^k*D | New device enable bits |
| gie_set_i | input | 1 | Set the global interrupt enable |
| ack_i | input | 1 | Core acknowledge of the interrupt |
| rti_i | input | 1 | Return-from-handler strobe |
| irq_o | output | 1 | Interrupt to the core |
| irq_lvl_o | output | k | Winning level |
| irq_pos_o | output | log2(D) | Winning slot within the level |
| dev_ack_o | output | 2^k*D | Per-device acknowledge |
| gie_o | output | 1 | Global interrupt enable state |
| cur_valid_o | output | 1 | A handler is running |
| cur_lvl_o | output | k | Level of the running handler |
| err_o | output | 1 | Sticky stack overflow/underflow flag |

## Verification
The bench targets three kinds of corner case. Two slots requesting in one level, with the lower slot disabled, catch a chain that grants a disabled device or picks the higher slot. A level-3 request arriving while a level-2 handler runs, with lower-level requests still pending, shows whether the mask opens only strictly higher levels. A mask that opens on equal levels would raise `irq_o` at once. A mask that stays closed would never preempt the handler. The bench also drives `ack_i` when no interrupt is pending, together with a return, and together with `gie_set_i`, to expose a design that pushes a context it should ignore or lets the set beat the clear. Finally it pops the stack one time more than it was pushed and expects a sticky error with the context left unchanged.

// File: rtl/nirq_pkg.sv
// Shared definitions for the nested interrupt controller.
// Assumes nothing beyond IEEE 1800-2017 packed types.
package nirq_pkg;

    // Operation requested of the level-context stack in one cycle.
    typedef enum logic [1:0] {
        STK_HOLD = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2
    } stk_op_e;

endpackage

// File: rtl/nirq_level_mask.sv
// Derives the per-level open mask from the running handler's level.
// Assumes a higher level number means higher priority; idle opens all.
module nirq_level_mask #(
    parameter int unsigned LVL_BITS = 2,
    localparam int unsigned LVLS    = 1 << LVL_BITS
) (
    input  logic                cur_busy_i,
    input  logic [LVL_BITS-1:0] cur_lvl_i,
    output logic [LVLS-1:0]     open_o
);

    for (genvar gl = 0; gl < LVLS; gl++) begin : g_lvl
        // Level gl is open when idle or strictly above the running level.
        assign open_o[gl] = !cur_busy_i || (LVL_BITS'(gl) > cur_lvl_i);
    end

endmodule

// File: rtl/nirq_daisy_chain.sv
// Daisy chain for the slots of one level: the token enters at slot 0,
// the first requesting slot keeps it. Requests must already be qualified.
module nirq_daisy_chain #(
    parameter int unsigned DEVS = 4,
    localparam int unsigned PB  = (DEVS > 1) ? $clog2(DEVS) : 1
) (
    input  logic            ack_in_i,
    input  logic [DEVS-1:0] req_i,
    output logic            any_o,
    output logic [PB-1:0]   pos_o,
    output logic [DEVS-1:0] grant_o
);

    logic [DEVS:0]   pass;
    logic [DEVS-1:0] hit;

    assign pass[0] = 1'b1;

    for (genvar gd = 0; gd < DEVS; gd++) begin : g_link
        // A slot keeps the token if it requests and the token reached it.
        assign hit[gd]      = req_i[gd] & pass[gd];
        assign pass[gd + 1] = pass[gd] & ~req_i[gd];
        assign grant_o[gd]  = ack_in_i & hit[gd];
    end

    assign any_o = ~pass[DEVS];

    // Encode the single holder of the token into a slot index.
    always_comb begin
        pos_o = '0;
        for (int i = 0; i < DEVS; i++) begin
            if (hit[i]) pos_o = pos_o | PB'(i);
        end
    end

endmodule

// File: rtl/nirq_level_pick.sv
// Selects the numerically highest level that has an eligible request.
// Assumes one "any" bit per level; reports zero when none is set.
module nirq_level_pick #(
    parameter int unsigned LVL_BITS = 2,
    localparam int unsigned LVLS    = 1 << LVL_BITS
) (
    input  logic [LVLS-1:0]     lvl_any_i,
    output logic                found_o,
    output logic [LVL_BITS-1:0] win_o
);

    // Scan upward so the highest level seen last wins.
    always_comb begin
        found_o = 1'b0;
        win_o   = '0;
        for (int l = 0; l < LVLS; l++) begin
            if (lvl_any_i[l]) begin
                found_o = 1'b1;
                win_o   = LVL_BITS'(l);
            end
        end
    end

endmodule

// File: rtl/nirq_level_stack.sv
// LIFO of saved handler contexts. A push when full and a pop when empty
// are refused and reported on the error pulses.
module nirq_level_stack
    import nirq_pkg::*;
#(
    parameter int unsigned DEPTH = 4,
    parameter int unsigned WIDTH = 3,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  stk_op_e          op_i,
    input  logic [WIDTH-1:0] push_data_i,
    output logic [WIDTH-1:0] top_o,
    output logic             empty_o,
    output logic             full_o,
    output logic             ovf_o,
    output logic             unf_o
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [CW-1:0]    cnt;
    logic [CW-1:0]    top_idx;

    assign empty_o = (cnt == '0);
    assign full_o  = (cnt == CW'(DEPTH));
    assign top_idx = cnt - CW'(1);
    assign top_o   = empty_o ? '0 : mem[top_idx[AW-1:0]];
    assign ovf_o   = (op_i == STK_PUSH) && full_o;
    assign unf_o   = (op_i == STK_POP) && empty_o;

    // Store a pushed context and move the fill count.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt <= '0;
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (op_i == STK_PUSH && !full_o) begin
            mem[cnt[AW-1:0]] <= push_data_i;
            cnt              <= cnt + CW'(1);
        end else if (op_i == STK_POP && !empty_o) begin
            cnt <= top_idx;
        end
    end

endmodule

// File: rtl/nested_irq_ctrl.sv
// Nested priority interrupt controller. Devices sit in 2^LVL_BITS levels
// of DEVS_PER_LVL slots; device d is level d/DEVS_PER_LVL, slot d%DEVS_PER_LVL.
// Assumes the core pulses ack_i for one cycle per taken interrupt and
// rti_i once per handler return.
module nested_irq_ctrl
    import nirq_pkg::*;
#(
    parameter int unsigned LVL_BITS     = 2,
    parameter int unsigned DEVS_PER_LVL = 4,
    localparam int unsigned LVLS        = 1 << LVL_BITS,
    localparam int unsigned NDEV        = LVLS * DEVS_PER_LVL,
    localparam int unsigned PB          = (DEVS_PER_LVL > 1) ? $clog2(DEVS_PER_LVL) : 1,
    localparam int unsigned CTXW        = LVL_BITS + 1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NDEV-1:0]     req_i,
    input  logic                en_we_i,
    input  logic [NDEV-1:0]     en_wdata_i,
    input  logic                gie_set_i,
    input  logic                ack_i,
    input  logic                rti_i,
    output logic                irq_o,
    output logic [LVL_BITS-1:0] irq_lvl_o,
    output logic [PB-1:0]       irq_pos_o,
    output logic [NDEV-1:0]     dev_ack_o,
    output logic                gie_o,
    output logic                cur_valid_o,
    output logic [LVL_BITS-1:0] cur_lvl_o,
    output logic                err_o
);

    logic [NDEV-1:0]     en_q;
    logic                gie_q;
    logic                busy_q;
    logic [LVL_BITS-1:0] lvl_q;
    logic                err_q;

    logic [LVLS-1:0]     lvl_open;
    logic [NDEV-1:0]     eligible;
    logic [LVLS-1:0]     lvl_any;
    logic [PB-1:0]       lvl_pos [LVLS];
    logic                found;
    logic [LVL_BITS-1:0] win_lvl;

    logic                ack_take;
    logic                rti_take;
    stk_op_e             stk_op;
    logic [CTXW-1:0]     stk_top;
    logic                stk_empty;
    logic                stk_full;
    logic                stk_ovf;
    logic                stk_unf;

    nirq_level_mask #(
        .LVL_BITS (LVL_BITS)
    ) i_mask (
        .cur_busy_i (busy_q),
        .cur_lvl_i  (lvl_q),
        .open_o     (lvl_open)
    );

    for (genvar gl = 0; gl < LVLS; gl++) begin : g_level
        logic [DEVS_PER_LVL-1:0] lvl_req;
        logic                    lvl_ack;

        // Qualify each request by its own enable and its level's mask bit.
        assign lvl_req = req_i[gl*DEVS_PER_LVL +: DEVS_PER_LVL]
                       & en_q[gl*DEVS_PER_LVL +: DEVS_PER_LVL]
                       & {DEVS_PER_LVL{lvl_open[gl]}};
        assign eligible[gl*DEVS_PER_LVL +: DEVS_PER_LVL] = lvl_req;
        assign lvl_ack = ack_take && (win_lvl == LVL_BITS'(gl));

        nirq_daisy_chain #(
            .DEVS (DEVS_PER_LVL)
        ) i_chain (
            .ack_in_i (lvl_ack),
            .req_i    (lvl_req),
            .any_o    (lvl_any[gl]),
            .pos_o    (lvl_pos[gl]),
            .grant_o  (dev_ack_o[gl*DEVS_PER_LVL +: DEVS_PER_LVL])
        );
    end

    nirq_level_pick #(
        .LVL_BITS (LVL_BITS)
    ) i_pick (
        .lvl_any_i (lvl_any),
        .found_o   (found),
        .win_o     (win_lvl)
    );

    // Accept decisions: a return outranks an acknowledge in the same cycle.
    assign ack_take = ack_i && irq_o && !rti_i;
    assign rti_take = rti_i && !stk_empty;

    // Map the accepted event onto a stack operation.
    always_comb begin
        if (rti_i)         stk_op = STK_POP;
        else if (ack_take) stk_op = STK_PUSH;
        else               stk_op = STK_HOLD;
    end

    nirq_level_stack #(
        .DEPTH (LVLS),
        .WIDTH (CTXW)
    ) i_stack (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .op_i        (stk_op),
        .push_data_i ({busy_q, lvl_q}),
        .top_o       (stk_top),
        .empty_o     (stk_empty),
        .full_o      (stk_full),
        .ovf_o       (stk_ovf),
        .unf_o       (stk_unf)
    );

    // Load the device enable register on a write strobe.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      en_q <= '0;
        else if (en_we_i) en_q <= en_wdata_i;
    end

    // Track the running handler's context and the global enable.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            gie_q  <= 1'b0;
            busy_q <= 1'b0;
            lvl_q  <= '0;
        end else if (rti_take) begin
            busy_q <= stk_top[CTXW-1];
            lvl_q  <= stk_top[LVL_BITS-1:0];
            gie_q  <= 1'b1;
        end else if (ack_take) begin
            busy_q <= 1'b1;
            lvl_q  <= win_lvl;
            gie_q  <= 1'b0;
        end else if (gie_set_i) begin
            gie_q  <= 1'b1;
        end
    end

    // Latch any stack misuse until reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) err_q <= 1'b0;
        else         err_q <= err_q | stk_ovf | stk_unf;
    end

    assign irq_o       = gie_q && found;
    assign irq_lvl_o   = win_lvl;
    assign irq_pos_o   = found ? lvl_pos[win_lvl] : '0;
    assign gie_o       = gie_q;
    assign cur_valid_o = busy_q;
    assign cur_lvl_o   = lvl_q;
    assign err_o       = err_q;

    // stk_full only feeds the overflow pulse inside the stack.
    logic unused_full;
    assign unused_full = stk_full;

endmodule

// File: rtl/nirq_checker.sv
// Port-level temporal checks for nested_irq_ctrl, bound to every instance.
module nirq_checker #(
    parameter int unsigned LVL_BITS     = 2,
    parameter int unsigned DEVS_PER_LVL = 4,
    localparam int unsigned LVLS        = 1 << LVL_BITS,
    localparam int unsigned NDEV        = LVLS * DEVS_PER_LVL,
    localparam int unsigned PB          = (DEVS_PER_LVL > 1) ? $clog2(DEVS_PER_LVL) : 1
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                gie_set_i,
    input logic                ack_i,
    input logic                rti_i,
    input logic                irq_o,
    input logic [LVL_BITS-1:0] irq_lvl_o,
    input logic [PB-1:0]       irq_pos_o,
    input logic [NDEV-1:0]     dev_ack_o,
    input logic                gie_o,
    input logic                cur_valid_o,
    input logic [LVL_BITS-1:0] cur_lvl_o,
    input logic                err_o
);

    logic acc;
    logic [$clog2(NDEV)-1:0] win_idx;
    assign acc     = ack_i && irq_o && !rti_i;
    assign win_idx = $clog2(NDEV)'(irq_lvl_o) * $clog2(NDEV)'(DEVS_PER_LVL)
                   + $clog2(NDEV)'(irq_pos_o);

    p_irq_needs_gie_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> gie_o);

    p_only_higher_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && cur_valid_o) |-> (irq_lvl_o > cur_lvl_o));

    p_grant_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(dev_ack_o));

    p_grant_needs_accept_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dev_ack_o != '0) |-> acc);

    p_grant_at_winner_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |-> dev_ack_o[win_idx]);

    p_ack_enters_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc |=> (!gie_o && cur_valid_o && cur_lvl_o == $past(irq_lvl_o)));

    p_gie_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gie_set_i && !acc) |=> gie_o);

    p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

endmodule

bind nested_irq_ctrl nirq_checker #(
    .LVL_BITS     (LVL_BITS),
    .DEVS_PER_LVL (DEVS_PER_LVL)
) i_nirq_checker (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gie_set_i   (gie_set_i),
    .ack_i       (ack_i),
    .rti_i       (rti_i),
    .irq_o       (irq_o),
    .irq_lvl_o   (irq_lvl_o),
    .irq_pos_o   (irq_pos_o),
    .dev_ack_o   (dev_ack_o),
    .gie_o       (gie_o),
    .cur_valid_o (cur_valid_o),
    .cur_lvl_o   (cur_lvl_o),
    .err_o       (err_o)
);

// File: tb/test_nested_irq_ctrl.sv
// Scoreboard bench: the driver applies one cycle of stimulus and queues the
// outputs expected in that cycle; the monitor compares them before the edge.
module test_nested_irq_ctrl;

    localparam int unsigned LB   = 2;
    localparam int unsigned D    = 4;
    localparam int unsigned NDEV = (1 << LB) * D;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NDEV-1:0] req = '0;
    logic            en_we = 1'b0;
    logic [NDEV-1:0] en_wdata = '0;
    logic            gie_set = 1'b0;
    logic            ack = 1'b0;
    logic            rti = 1'b0;
    logic            irq;
    logic [LB-1:0]   irq_lvl;
    logic [1:0]      irq_pos;
    logic [NDEV-1:0] dev_ack;
    logic            gie;
    logic            cur_valid;
    logic [LB-1:0]   cur_lvl;
    logic            err;

    always #10 clk = ~clk;  // 50 MHz

    nested_irq_ctrl #(.LVL_BITS(LB), .DEVS_PER_LVL(D)) i_nested_irq_ctrl (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .en_we_i(en_we),
        .en_wdata_i(en_wdata), .gie_set_i(gie_set), .ack_i(ack), .rti_i(rti),
        .irq_o(irq), .irq_lvl_o(irq_lvl), .irq_pos_o(irq_pos),
        .dev_ack_o(dev_ack), .gie_o(gie), .cur_valid_o(cur_valid),
        .cur_lvl_o(cur_lvl), .err_o(err)
    );

    typedef struct {
        string      tag;
        logic [25:0] val;
    } item_t;

    item_t q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 1'b0;

    // Drive one cycle of inputs and queue what the ports must show in it.
    task automatic step(input string tag, input logic [15:0] r, input logic we,
                        input logic [15:0] wd, input logic gs, input logic a,
                        input logic rt, input logic e_irq, input logic [1:0] e_lvl,
                        input logic [1:0] e_pos, input logic [15:0] e_dack,
                        input logic e_gie, input logic e_cv, input logic [1:0] e_cl,
                        input logic e_err);
        item_t it;
        @(negedge clk);
        req = r; en_we = we; en_wdata = wd; gie_set = gs; ack = a; rti = rt;
        it.tag = tag;
        it.val = {e_irq, e_lvl, e_pos, e_dack, e_gie, e_cv, e_cl, e_err};
        q.push_back(it);
    endtask

    // Monitor: compare queued expectations a quarter period before the edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                logic [25:0] got;
                it  = q.pop_front();
                got = {irq, irq_lvl, irq_pos, dev_ack, gie, cur_valid, cur_lvl, err};
                n_checks++;
                if (got !== it.val) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, got, it.val);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        //    tag                  req     we wdata   gs a  rt  irq lvl pos dack   gie cv cl err
        step("R1 reset state",    16'h0000,0,16'h0000,0,0,0,  0,0,0,16'h0000,0,0,0,0);
        step("R2 enable pending", 16'h0002,1,16'hFFFF,0,0,0,  0,0,0,16'h0000,0,0,0,0);
        step("R3 gie low",        16'h0002,0,16'h0000,1,0,0,  0,0,1,16'h0000,0,0,0,0);
        step("R3 irq raised",     16'h0002,0,16'h0000,0,0,0,  1,0,1,16'h0000,1,0,0,0);
        step("R4 R5 top level",   16'h0A12,0,16'h0000,0,0,0,  1,2,1,16'h0000,1,0,0,0);
        step("R2 disable write",  16'h0A12,1,16'hFDFF,0,0,0,  1,2,1,16'h0000,1,0,0,0);
        step("R2 R5 slot skip",   16'h0A12,0,16'h0000,0,0,0,  1,2,3,16'h0000,1,0,0,0);
        step("R6 chain grant",    16'h0A12,0,16'h0000,0,1,0,  1,2,3,16'h0800,1,0,0,0);
        step("R7 R2 entered",     16'h0A12,0,16'h0000,0,0,0,  0,0,0,16'h0000,0,1,2,0);
        step("R8 gie pending",    16'h4A12,0,16'h0000,1,0,0,  0,3,2,16'h0000,0,1,2,0);
        step("R4 nested grant",   16'h4A12,0,16'h0000,0,1,0,  1,3,2,16'h4000,1,1,2,0);
        step("R11 ack no irq",    16'h4A12,0,16'h0000,0,1,0,  0,0,0,16'h0000,0,1,3,0);
        step("R11 ack ignored",   16'h4A12,0,16'h0000,0,0,1,  0,0,0,16'h0000,0,1,3,0);
        step("R9 pop to lvl2",    16'h4A12,0,16'h0000,0,1,1,  1,3,2,16'h0000,1,1,2,0);
        step("R9 R11 pop idle",   16'h0A12,0,16'h0000,0,0,1,  1,2,3,16'h0000,1,0,0,0);
        step("R10 underflow",     16'h0A12,0,16'h0000,0,0,0,  1,2,3,16'h0000,1,0,0,1);
        step("R10 err sticky",    16'h0A12,0,16'h0000,1,1,0,  1,2,3,16'h0800,1,0,0,1);
        step("R8 clear wins",     16'h0A12,0,16'h0000,0,0,0,  0,0,0,16'h0000,0,1,2,1);
        step("R1 idle tail",      16'h0A12,0,16'h0000,0,0,0,  0,0,0,16'h0000,0,1,2,1);
        @(negedge clk);
        req = '0; ack = 1'b0; gie_set = 1'b0; rti = 1'b0;
        while (q.size() > 0) @(negedge clk);
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule